// File: doc/BRIEF.md
# Systolic Sine Series Pipeline

This block evaluates sin x as the three-term odd polynomial x − x³/6 + x⁵/120 with a linear chain of identical processing elements. Each element adds one term to a running sum and hands the next element everything it needs to form the following term: the angle itself, the current odd power of the angle, the odd index, the factorial of that index and the sign of the next term. Because every element is registered, a fresh angle can enter on every clock, and a result leaves on every clock once the chain has filled.

Angles arrive as signed Q2.14 values meant to lie within ±π/2; results leave as signed Q1.15 values. Division by each stage's factorial is replaced by multiplication with a rounded fixed-point reciprocal worked out at elaboration. A valid flag travels with every sample, and the input angle is returned beside its result so a consumer can pair them without its own delay line.

Top module: `sine_systolic_chain`

## Requirements
- R1: While reset is high and in the cycles right after it, out_valid stays low; reset clears the valid flag of every stage.
- R2: out_valid is high exactly 3 clock cycles after each cycle in which in_valid was high, with gaps in the input reproduced unchanged at the output.
- R3: With out_valid high, out_angle equals the in_angle that entered 3 cycles earlier, bit for bit.
- R4: With out_valid high, out_sine (Q1.15, value/32768) is within 3 LSB of round(32768·(x − x³/6 + x⁵/120)), where x = in_angle/16384 (Q2.14) lies in [−π/2, π/2].
- R5: When the polynomial value is above 32767/32768 the result is 32767, and when it is below −1 the result is −32768 (the polynomial reaches about ±1.0045 at ±π/2).
- R6: Angles fed on consecutive cycles produce results on consecutive cycles: N back-to-back angles have all left the block N + 3 cycles after the first one entered.
- R7: An angle of exactly 0 gives a result of exactly 0.
- R8: A cycle with in_valid low is ignored: it never produces a high out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks in_angle as a sample to evaluate |
| in_angle | input | 16 | Signed Q2.14 angle in radians |
| out_valid | output | 1 | Marks out_sine and out_angle as a result |
| out_sine | output | 16 | Signed Q1.15 sine estimate, saturated |
| out_angle | output | 16 | The angle the result belongs to |

## Verification
Zero separates a chain that leaks rounding bias into the sum from one that keeps every term exactly zero, while ±π/2 and ±1 rad exercise the largest fifth-power term and both saturation directions. A constrained random sweep across the full angle range, with the valid line dropping about a quarter of the time, compares every result with a real-valued polynomial and shows whether the per-stage sign, power and reciprocal line up. A back-to-back burst followed by an output count tells a stalling or bubble-inserting pipeline apart from one that delivers a result per clock, and the idle cycles between bursts expose any stage that forwards a stale valid.

// File: rtl/sine_pkg.sv
package sine_pkg;

   // Factorial of the odd index 2k+1 seen by stage k.
   function automatic longint odd_fact(input int k);
      longint acc;
      acc = 1;
      for (int i = 2; i <= 2 * k + 1; i++) begin
         acc = acc * longint'(i);
      end
      return acc;
   endfunction

   // Rounded reciprocal of that factorial with frac fractional bits.
   function automatic longint recip_q(input int k, input int frac);
      longint f;
      f = odd_fact(k);
      return ((longint'(1) <<< frac) + f / 2) / f;
   endfunction

endpackage

// File: rtl/sine_stage.sv
module sine_stage #(
   parameter int IDX      = 0,
   parameter int ANG_W    = 16,
   parameter int ANG_FRAC = 14,
   parameter int A_W      = 20,
   parameter int SUM_W    = 20,
   parameter int SUM_FRAC = 16,
   parameter int REC_FRAC = 20,
   parameter int P_W      = 8,
   parameter int F_W      = 24
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    v_i,
   input  logic signed [ANG_W-1:0] x_i,
   input  logic signed [A_W-1:0]   a_i,
   input  logic signed [SUM_W-1:0] s_i,
   input  logic [P_W-1:0]          p_i,
   input  logic [F_W-1:0]          f_i,
   input  logic                    u_i,
   output logic                    v_o,
   output logic signed [ANG_W-1:0] x_o,
   output logic signed [A_W-1:0]   a_o,
   output logic signed [SUM_W-1:0] s_o,
   output logic [P_W-1:0]          p_o,
   output logic [F_W-1:0]          f_o,
   output logic                    u_o
);

   localparam int PAX_W = A_W + ANG_W;
   localparam int REC_W = REC_FRAC + 2;
   localparam int PT_W  = A_W + REC_W;
   localparam int T_SH  = ANG_FRAC + REC_FRAC - SUM_FRAC;

   localparam logic signed [REC_W-1:0] RECIP   = REC_W'(sine_pkg::recip_q(IDX, REC_FRAC));
   localparam logic signed [PAX_W-1:0] AX_HALF = PAX_W'(1) <<< (ANG_FRAC - 1);
   localparam logic signed [PT_W-1:0]  T_HALF  = PT_W'(1) <<< (T_SH - 1);

   if (T_SH < 1) begin : g_bad_shift
      $error("sine_stage: reciprocal precision too low for the sum format");
   end
   if (ANG_FRAC < 1) begin : g_bad_frac
      $error("sine_stage: angle needs fractional bits");
   end

   logic signed [PAX_W-1:0] ax_full;
   logic signed [A_W-1:0]   ax;
   logic signed [PAX_W-1:0] pow_full;
   logic signed [A_W-1:0]   pow_nx;
   logic signed [PT_W-1:0]  t_full;
   logic signed [SUM_W-1:0] term;
   logic                    neg_nx;
   logic signed [SUM_W-1:0] sum_nx;
   logic [P_W-1:0]          p_nx;
   logic [F_W-1:0]          p_ext;
   logic [F_W-1:0]          f_nx;

   always_comb begin
      // a_in * x, rounded back to the power-term format
      ax_full  = a_i * x_i;
      ax       = A_W'((ax_full + AX_HALF) >>> ANG_FRAC);
      // next power term a_in * x^2 = (a_in * x) * x
      pow_full = ax * x_i;
      pow_nx   = A_W'((pow_full + AX_HALF) >>> ANG_FRAC);
      // a_in * x / f_in through the constant reciprocal
      t_full   = ax * RECIP;
      term     = SUM_W'((t_full + T_HALF) >>> T_SH);
      neg_nx   = ~u_i;
      sum_nx   = neg_nx ? (s_i - term) : (s_i + term);
      p_nx     = p_i + P_W'(2);
      p_ext    = F_W'(p_i);
      f_nx     = (p_ext + F_W'(2)) * (p_ext + F_W'(1)) * f_i;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         v_o <= 1'b0;
      end else begin
         v_o <= v_i;
      end
   end

   always_ff @(posedge clk) begin
      x_o <= x_i;
      a_o <= pow_nx;
      s_o <= sum_nx;
      p_o <= p_nx;
      f_o <= f_nx;
      u_o <= neg_nx;
   end

   // R1: reset clears this stage's valid flag
   assert_reset_clear_R1: assert property (@(posedge clk) rst |=> !v_o);

   if (IDX > 0) begin : g_state_chk
      // R4: the series state handed over by the previous stage matches this index
      assert_series_state_R4: assert property (@(posedge clk) disable iff (rst)
         v_i |-> ((p_i == P_W'(2 * IDX + 1)) &&
                  (f_i == F_W'(sine_pkg::odd_fact(IDX))) &&
                  (u_i == ((IDX % 2) == 0))));
   end

endmodule

// File: rtl/sine_out_fmt.sv
module sine_out_fmt #(
   parameter int SUM_W    = 20,
   parameter int SUM_FRAC = 16,
   parameter int OUT_W    = 16,
   parameter int OUT_FRAC = 15
) (
   input  logic signed [SUM_W-1:0] s_i,
   output logic signed [OUT_W-1:0] y_o
);

   localparam int SH = SUM_FRAC - OUT_FRAC;
   localparam logic signed [SUM_W-1:0] Y_MAX = SUM_W'((longint'(1) <<< (OUT_W - 1)) - 1);
   localparam logic signed [SUM_W-1:0] Y_MIN = -Y_MAX - SUM_W'(1);

   if (SH < 0) begin : g_bad_frac
      $error("sine_out_fmt: output has more fraction bits than the sum");
   end
   if (OUT_W > SUM_W) begin : g_bad_width
      $error("sine_out_fmt: output wider than the sum");
   end

   logic signed [SUM_W-1:0] scaled;

   if (SH > 0) begin : g_round
      localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1) <<< (SH - 1);
      assign scaled = (s_i + HALF) >>> SH;
   end else begin : g_pass
      assign scaled = s_i;
   end

   always_comb begin
      if (scaled > Y_MAX) begin
         y_o = OUT_W'(Y_MAX);
      end else if (scaled < Y_MIN) begin
         y_o = OUT_W'(Y_MIN);
      end else begin
         y_o = OUT_W'(scaled);
      end
   end

endmodule

// File: rtl/sine_systolic_chain.sv
module sine_systolic_chain #(
   parameter int N_TERMS  = 3,
   parameter int ANG_W    = 16,
   parameter int ANG_FRAC = 14,
   parameter int OUT_W    = 16,
   parameter int OUT_FRAC = 15,
   parameter int SUM_FRAC = 16,
   parameter int REC_FRAC = 20
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    in_valid,
   input  logic signed [ANG_W-1:0] in_angle,
   output logic                    out_valid,
   output logic signed [OUT_W-1:0] out_sine,
   output logic signed [ANG_W-1:0] out_angle
);

   localparam int A_W   = ANG_W + 4;
   localparam int SUM_W = SUM_FRAC + 4;
   localparam int P_W   = 8;
   localparam int F_W   = 24;

   if ((N_TERMS < 1) || (N_TERMS > 4)) begin : g_bad_terms
      $error("sine_systolic_chain: N_TERMS must lie in 1..4");
   end
   if ((ANG_W - ANG_FRAC) < 2) begin : g_bad_angle
      $error("sine_systolic_chain: angle format cannot hold pi/2");
   end
   if (OUT_FRAC > SUM_FRAC) begin : g_bad_out
      $error("sine_systolic_chain: sum must carry the output precision");
   end

   logic                    v_c [0:N_TERMS];
   logic signed [ANG_W-1:0] x_c [0:N_TERMS];
   logic signed [A_W-1:0]   a_c [0:N_TERMS];
   logic signed [SUM_W-1:0] s_c [0:N_TERMS];
   logic [P_W-1:0]          p_c [0:N_TERMS];
   logic [F_W-1:0]          f_c [0:N_TERMS];
   logic                    u_c [0:N_TERMS];

   // seed of the first element: empty sum, unit power, index 1, 1! and a negative sign
   assign v_c[0] = in_valid;
   assign x_c[0] = in_angle;
   assign a_c[0] = A_W'(1) <<< ANG_FRAC;
   assign s_c[0] = '0;
   assign p_c[0] = P_W'(1);
   assign f_c[0] = F_W'(1);
   assign u_c[0] = 1'b1;

   for (genvar k = 0; k < N_TERMS; k++) begin : g_pe
      sine_stage #(
         .IDX      (k),
         .ANG_W    (ANG_W),
         .ANG_FRAC (ANG_FRAC),
         .A_W      (A_W),
         .SUM_W    (SUM_W),
         .SUM_FRAC (SUM_FRAC),
         .REC_FRAC (REC_FRAC),
         .P_W      (P_W),
         .F_W      (F_W)
      ) u_pe (
         .clk (clk),
         .rst (rst),
         .v_i (v_c[k]),
         .x_i (x_c[k]),
         .a_i (a_c[k]),
         .s_i (s_c[k]),
         .p_i (p_c[k]),
         .f_i (f_c[k]),
         .u_i (u_c[k]),
         .v_o (v_c[k+1]),
         .x_o (x_c[k+1]),
         .a_o (a_c[k+1]),
         .s_o (s_c[k+1]),
         .p_o (p_c[k+1]),
         .f_o (f_c[k+1]),
         .u_o (u_c[k+1])
      );
   end

   sine_out_fmt #(
      .SUM_W    (SUM_W),
      .SUM_FRAC (SUM_FRAC),
      .OUT_W    (OUT_W),
      .OUT_FRAC (OUT_FRAC)
   ) u_fmt (
      .s_i (s_c[N_TERMS]),
      .y_o (out_sine)
   );

   assign out_valid = v_c[N_TERMS];
   assign out_angle = x_c[N_TERMS];

   // R2: a result only appears where an input was accepted N_TERMS cycles before
   assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid, N_TERMS));

   // R3: the angle beside a result is the one that produced it
   assert_angle_forward_R3: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_angle == $past(in_angle, N_TERMS)));

   // R7: a zero angle that has travelled the chain yields a zero result
   assert_zero_angle_R7: assert property (@(posedge clk) disable iff (rst)
      (out_valid && (out_angle == '0)) |-> (out_sine == '0));

endmodule

// File: tb/sine_systolic_chain_tb.sv
module sine_systolic_chain_tb;

   localparam int LAT = 3;

   logic               clk;
   logic               rst;
   logic               in_valid;
   logic signed [15:0] in_angle;
   logic               out_valid;
   logic signed [15:0] out_sine;
   logic signed [15:0] out_angle;

   int  n_chk;
   int  n_fail;
   int  n_out;
   bit  rst_req;
   bit  hv [1:LAT];
   int  hx [1:LAT];

   sine_systolic_chain u_dut (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_angle  (in_angle),
      .out_valid (out_valid),
      .out_sine  (out_sine),
      .out_angle (out_angle)
   );

   initial clk = 1'b0;
   always #2 clk = ~clk;

   function automatic int exp_sine(input int xi);
      real xr;
      real y;
      real e;
      int  r;
      xr = real'(xi) / 16384.0;
      y  = xr - (xr * xr * xr) / 6.0 + (xr * xr * xr * xr * xr) / 120.0;
      e  = y * 32768.0;
      if (e >= 0.0) r = $rtoi(e + 0.5);
      else          r = -$rtoi(-e + 0.5);
      if (r > 32767)  r = 32767;
      if (r < -32768) r = -32768;
      return r;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic step(input bit v, input int x);
      int e;
      int d;
      @(negedge clk);
      if (rst) begin
         chk(out_valid == 1'b0, "R1 valid during reset", int'(out_valid), 0);
      end else if (hv[LAT]) begin
         chk(out_valid == 1'b1, "R2 valid after latency", int'(out_valid), 1);
         chk(int'(out_angle) == hx[LAT], "R3 forwarded angle", int'(out_angle), hx[LAT]);
         e = exp_sine(hx[LAT]);
         d = int'(out_sine) - e;
         if (hx[LAT] == 0) begin
            chk(out_sine == 16'sd0, "R7 zero angle", int'(out_sine), 0);
         end else if ((hx[LAT] >= 25700) || (hx[LAT] <= -25700)) begin
            chk(int'(out_sine) == e, "R5 saturation", int'(out_sine), e);
         end else if ((e == 32767) || (e == -32768)) begin
            chk((d <= 3) && (d >= -3), "R5 near limit", int'(out_sine), e);
         end else begin
            chk((d <= 3) && (d >= -3), "R4 polynomial value", int'(out_sine), e);
         end
      end else begin
         chk(out_valid == 1'b0, "R8 idle cycle ignored", int'(out_valid), 0);
      end
      if (!rst && out_valid) n_out++;
      for (int i = LAT; i > 1; i--) begin
         hv[i] = hv[i-1];
         hx[i] = hx[i-1];
      end
      rst      = rst_req;
      in_valid = v;
      in_angle = 16'(x);
      hv[1]    = v && !rst_req;
      hx[1]    = x;
   endtask

   function automatic int rnd_angle();
      return int'($urandom_range(51470)) - 25735;
   endfunction

   initial begin
      #(4 * 200000);
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
   end

   initial begin
      int n0;
      void'($urandom(32'd24681357));
      n_chk    = 0;
      n_fail   = 0;
      n_out    = 0;
      rst      = 1'b1;
      rst_req  = 1'b1;
      in_valid = 1'b0;
      in_angle = '0;
      for (int i = 1; i <= LAT; i++) begin
         hv[i] = 1'b0;
         hx[i] = 0;
      end

      // R1: reset held, valid inputs offered but not accepted
      repeat (4) step(1'b1, 1000);
      rst_req = 1'b0;
      repeat (4) step(1'b0, 0);

      // directed corners: zero (R7), both limits (R5), unit angles and tiny angles (R4)
      step(1'b1, 0);
      step(1'b1, 25736);
      step(1'b1, -25736);
      step(1'b1, 16384);
      step(1'b1, -16384);
      step(1'b1, 1);
      step(1'b1, -1);
      step(1'b1, 8192);
      step(1'b0, 0);
      step(1'b1, 25735);
      step(1'b0, 0);
      step(1'b0, 0);
      step(1'b1, -25735);
      repeat (LAT) step(1'b0, 0);

      // R6: back-to-back burst, every result out by N + 3 cycles
      n0 = n_out;
      for (int i = 0; i < 40; i++) step(1'b1, rnd_angle());
      repeat (LAT) step(1'b0, 0);
      chk(n_out - n0 == 40, "R6 burst throughput", n_out - n0, 40);

      // random sweep with gaps (R2, R4, R8)
      for (int i = 0; i < 2000; i++) begin
         if ($urandom_range(3) != 0) step(1'b1, rnd_angle());
         else                        step(1'b0, 0);
      end
      repeat (LAT + 2) step(1'b0, 0);

      // reset in the middle of traffic clears the pipeline (R1)
      step(1'b1, 5000);
      step(1'b1, 6000);
      rst_req = 1'b1;
      step(1'b1, 7000);
      repeat (3) step(1'b0, 0);
      rst_req = 1'b0;
      repeat (LAT + 2) step(1'b0, 0);

      summary();
      $finish;
   end

endmodule